// File: doc/BRIEF.md
# Receive-Path Decoder for a PHY/Link Interface

This block sits on the link side of a PHY/link interface with a two-bit control bus and an eight-bit data bus. It looks at both buses on every clock. When it sees the all-ones data-prefix marker under the receive control code, it takes the next non-prefix data value as an in-band speed code and decodes it. From then on it packs the data-bus values into payload bytes. The speed code sets how many data pins carry payload on each cycle.

Each payload byte goes out on a valid/data/last stream. A start-of-packet flag marks the first byte, and the decoded speed is held beside the bytes. The speed byte never enters the stream, so a downstream CRC checker sees payload only. The packet ends when the control bus returns to idle. A reception made only of prefix and then idle is a speed-capability probe, and it ends with no output. A one-cycle error pulse marks three malformed cases: a partly packed byte at idle, an unknown speed code, and an illegal control code during a reception.

Data pin `dat_i[DATA_W-1]` is the first pin of the bus and carries the most significant payload bit.

Top module: `rx_path_decoder`

## Requirements
- R1: While `rst_n` is low, `rx_valid_o`, `rx_sop_o`, `rx_last_o` and `rx_err_o` are 0. After reset the block waits for a data prefix, and no earlier bus activity affects it.
- R2: A reception starts only when `ctl_i` is 2'b10 (receive) and every data pin is 1. While `ctl_i` is 2'b00 (idle) the data pins are ignored. Receive with any other data value, and codes 2'b01 and 2'b11, are ignored while the block waits.
- R3: The first non-prefix value after the marker is the speed code. Codes matching 00xxxxxx select S100 (`rx_speed_o` = 2'b00). Codes matching 0100xxxx select S200 (2'b01). Code 01010000 selects S400 (2'b10). Bit 7 is the leftmost bit of each pattern.
- R4: Values matching 11xxxxxx after the marker are further prefix. Neither they nor the speed code appear in the byte stream.
- R5: Each receive cycle adds payload bits from the top data pins: two bits at S100 (4 cycles per byte), four bits at S200 (2 cycles per byte) and all eight at S400. Bits are packed most significant first, and the unused lower pins are ignored.
- R6: `rx_sop_o` is high together with `rx_valid_o` on the first byte of a packet and on no other byte. `rx_speed_o` holds the decoded speed on every byte of the packet.
- R7: When `ctl_i` returns to idle, the last complete byte is delivered with `rx_last_o` high. No other byte has it.
- R8: A prefix followed directly by idle gives no byte and no error. A speed code followed directly by idle gives the same result.
- R9: If idle arrives while a byte is only partly packed, the partial bits are dropped and `rx_err_o` pulses once. The complete bytes are still delivered, and the last of them carries `rx_last_o`.
- R10: A speed code outside the R3 patterns gives one `rx_err_o` pulse and no bytes. The buses are then ignored until idle.
- R11: Control code 2'b01 or 2'b11 after the marker aborts the reception. `rx_err_o` pulses once. The byte held for delivery is dropped, so no `rx_last_o` appears, and the buses are ignored until idle.
- R12: `rx_err_o` never stays high for two cycles. `rx_last_o` and `rx_sop_o` are only high with `rx_valid_o`, and a byte carrying `rx_last_o` is never followed by a valid in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Asserts asynchronously, released synchronously upstream |
| ctl_i | input | 2 | Control bus from the PHY (00 idle, 10 receive) |
| dat_i | input | DATA_W | Data bus from the PHY; bit DATA_W-1 is the first pin |
| rx_valid_o | output | 1 | Payload byte valid |
| rx_data_o | output | DATA_W | Payload byte |
| rx_last_o | output | 1 | Final byte of the packet |
| rx_sop_o | output | 1 | First byte of the packet |
| rx_speed_o | output | 2 | Decoded speed: 00 S100, 01 S200, 10 S400 |
| rx_err_o | output | 1 | One-cycle malformed-reception pulse |

## Verification
Several stream rules are checked by assertions on every cycle: the shape of the error pulse, last and start only with valid, no valid straight after a last, a steady speed within a packet, a packing counter that stays inside the byte for the current speed, an error after an illegal control code, and silence after a prefix-only probe. Only the bench scenarios can show that payload values come out in the right order and with the right bit packing. They also show that prefix repeats and the speed byte are kept out of the stream, that the last flag falls on the right byte, and that aborted and bad-code receptions drop the bytes they should. These scenarios also cover a reset in the middle of a reception.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  typedef enum logic [1:0] {
    SPD_S100 = 2'b00,
    SPD_S200 = 2'b01,
    SPD_S400 = 2'b10
  } rx_speed_e;

  typedef enum logic [1:0] {
    ST_WAIT   = 2'b00,
    ST_PREFIX = 2'b01,
    ST_DATA   = 2'b10,
    ST_DRAIN  = 2'b11
  } rx_state_e;

  localparam logic [1:0] CTL_IDLE = 2'b00;
  localparam logic [1:0] CTL_RECV = 2'b10;

endpackage

// File: rtl/rxd_speed_decode.sv
module rxd_speed_decode
  import rxd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] code_i,
  output logic              is_prefix_o,
  output logic              code_ok_o,
  output rx_speed_e         speed_o
);

  localparam logic [DATA_W-1:0] S400_CODE = {4'b0101, {(DATA_W-4){1'b0}}};

  logic hit_s100, hit_s200, hit_s400;

  always_comb begin
    is_prefix_o = (code_i[DATA_W-1 -: 2] == 2'b11);
    hit_s100    = (code_i[DATA_W-1 -: 2] == 2'b00);
    hit_s200    = (code_i[DATA_W-1 -: 4] == 4'b0100);
    hit_s400    = (code_i == S400_CODE);
    code_ok_o   = hit_s100 | hit_s200 | hit_s400;
    if (hit_s400)      speed_o = SPD_S400;
    else if (hit_s200) speed_o = SPD_S200;
    else               speed_o = SPD_S100;
  end

endmodule

// File: rtl/rxd_bit_packer.sv
module rxd_bit_packer
  import rxd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              shift_en_i,
  input  rx_speed_e         speed_i,
  input  logic [DATA_W-1:0] pins_i,
  output logic              byte_done_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              partial_o
);

  localparam int QW    = DATA_W / 4;
  localparam int HW    = DATA_W / 2;
  localparam int CNT_W = 2;

  logic [DATA_W-1:0] acc_q, acc_d, lane;
  logic [CNT_W-1:0]  cnt_q, cnt_d, last_idx;

  always_comb begin
    case (speed_i)
      SPD_S100: begin
        lane     = {acc_q[DATA_W-QW-1:0], pins_i[DATA_W-1 -: QW]};
        last_idx = 2'd3;
      end
      SPD_S200: begin
        lane     = {acc_q[DATA_W-HW-1:0], pins_i[DATA_W-1 -: HW]};
        last_idx = 2'd1;
      end
      default: begin
        lane     = pins_i;
        last_idx = 2'd0;
      end
    endcase
  end

  always_comb begin
    byte_done_o = shift_en_i && (cnt_q == last_idx);
    byte_o      = lane;
    partial_o   = (cnt_q != '0);
    acc_d       = acc_q;
    cnt_d       = cnt_q;
    if (clear_i) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (shift_en_i) begin
      acc_d = lane;
      cnt_d = byte_done_o ? '0 : CNT_W'(cnt_q + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (clear_i || shift_en_i) begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  // R5
  s400_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_i == SPD_S400) |-> (cnt_q == '0));

  // R5
  s200_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_i == SPD_S200) |-> (cnt_q <= 2'd1));

endmodule

// File: rtl/rxd_out_stage.sv
module rxd_out_stage
  import rxd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              finish_i,
  input  logic              discard_i,
  input  logic              err_i,
  input  rx_speed_e         speed_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o,
  output logic              sop_o,
  output logic [1:0]        speed_o,
  output logic              err_o
);

  logic              pend_vld_q, pend_vld_d;
  logic [DATA_W-1:0] pend_q;
  logic              first_q, first_d;
  logic              emit;
  logic              valid_d, last_d, sop_d;

  always_comb begin
    emit       = pend_vld_q && (push_i || finish_i);
    valid_d    = emit;
    last_d     = emit && finish_i;
    sop_d      = emit && first_q;
    pend_vld_d = pend_vld_q;
    if (discard_i || finish_i) pend_vld_d = 1'b0;
    else if (push_i)           pend_vld_d = 1'b1;
    first_d = first_q;
    if (start_i)   first_d = 1'b1;
    else if (emit) first_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld_q <= 1'b0;
      first_q    <= 1'b0;
      valid_o    <= 1'b0;
      last_o     <= 1'b0;
      sop_o      <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      pend_vld_q <= pend_vld_d;
      first_q    <= first_d;
      valid_o    <= valid_d;
      last_o     <= last_d;
      sop_o      <= sop_d;
      err_o      <= err_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      data_o  <= '0;
      speed_o <= SPD_S100;
    end else begin
      if (push_i) pend_q <= push_data_i;
      if (emit) begin
        data_o  <= pend_q;
        speed_o <= speed_i;
      end
    end
  end

  // R12
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  // R12
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  // R6
  sop_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sop_o |-> valid_o);

  // R12
  gap_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && last_o) |=> !valid_o);

  // R6
  speed_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !sop_o) |-> $stable(speed_o));

endmodule

// File: rtl/rx_path_decoder.sv
module rx_path_decoder
  import rxd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ctl_i,
  input  logic [DATA_W-1:0] dat_i,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_last_o,
  output logic              rx_sop_o,
  output logic [1:0]        rx_speed_o,
  output logic              rx_err_o
);

  rx_state_e state_q, state_d;
  rx_speed_e speed_q, speed_d;

  logic is_idle, is_recv;
  logic dec_prefix, dec_ok;
  rx_speed_e dec_speed;
  logic start, shift, finish, discard, err_d;
  logic pk_done, pk_partial;
  logic [DATA_W-1:0] pk_byte;

  assign is_idle = (ctl_i == CTL_IDLE);
  assign is_recv = (ctl_i == CTL_RECV);

  rxd_speed_decode #(.DATA_W(DATA_W)) speed_dec_i (
    .code_i      (dat_i),
    .is_prefix_o (dec_prefix),
    .code_ok_o   (dec_ok),
    .speed_o     (dec_speed)
  );

  always_comb begin
    state_d = state_q;
    speed_d = speed_q;
    start   = 1'b0;
    shift   = 1'b0;
    finish  = 1'b0;
    discard = 1'b0;
    err_d   = 1'b0;
    case (state_q)
      ST_WAIT: begin
        if (is_recv && (&dat_i)) state_d = ST_PREFIX;
      end
      ST_PREFIX: begin
        if (is_idle) begin
          state_d = ST_WAIT;
        end else if (!is_recv) begin
          err_d   = 1'b1;
          state_d = ST_DRAIN;
        end else if (!dec_prefix) begin
          if (dec_ok) begin
            state_d = ST_DATA;
            speed_d = dec_speed;
            start   = 1'b1;
          end else begin
            err_d   = 1'b1;
            state_d = ST_DRAIN;
          end
        end
      end
      ST_DATA: begin
        if (is_recv) begin
          shift = 1'b1;
        end else if (is_idle) begin
          finish  = 1'b1;
          err_d   = pk_partial;
          state_d = ST_WAIT;
        end else begin
          err_d   = 1'b1;
          discard = 1'b1;
          state_d = ST_DRAIN;
        end
      end
      default: begin
        if (is_idle) state_d = ST_WAIT;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      speed_q <= SPD_S100;
    end else begin
      state_q <= state_d;
      if (start) speed_q <= speed_d;
    end
  end

  rxd_bit_packer #(.DATA_W(DATA_W)) packer_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (state_q != ST_DATA),
    .shift_en_i  (shift),
    .speed_i     (speed_q),
    .pins_i      (dat_i),
    .byte_done_o (pk_done),
    .byte_o      (pk_byte),
    .partial_o   (pk_partial)
  );

  rxd_out_stage #(.DATA_W(DATA_W)) out_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .push_i      (pk_done),
    .push_data_i (pk_byte),
    .finish_i    (finish),
    .discard_i   (discard),
    .err_i       (err_d),
    .speed_i     (speed_q),
    .valid_o     (rx_valid_o),
    .data_o      (rx_data_o),
    .last_o      (rx_last_o),
    .sop_o       (rx_sop_o),
    .speed_o     (rx_speed_o),
    .err_o       (rx_err_o)
  );

  // R11
  abort_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && !is_recv && !is_idle) |=> rx_err_o);

  // R8
  silent_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PREFIX && is_idle) |=> (!rx_err_o && !rx_valid_o));

endmodule

// File: tb/rx_path_decoder_tb_top.sv
`timescale 1ns/1ps
module rx_path_decoder_tb_top;

  logic       clk;
  logic       rst_n;
  logic [1:0] ctl_i;
  logic [7:0] dat_i;
  logic       rx_valid_o, rx_last_o, rx_sop_o, rx_err_o;
  logic [7:0] rx_data_o;
  logic [1:0] rx_speed_o;

  int n_chk, n_bad;
  bit done;

  logic [7:0] cap_data [64];
  logic       cap_last [64];
  logic       cap_sop  [64];
  logic [1:0] cap_spd  [64];
  int cap_n, err_n;

  rx_path_decoder #(.DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_i(ctl_i), .dat_i(dat_i),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o), .rx_last_o(rx_last_o),
    .rx_sop_o(rx_sop_o), .rx_speed_o(rx_speed_o), .rx_err_o(rx_err_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid_o && cap_n < 64) begin
        cap_data[cap_n] = rx_data_o;
        cap_last[cap_n] = rx_last_o;
        cap_sop[cap_n]  = rx_sop_o;
        cap_spd[cap_n]  = rx_speed_o;
        cap_n = cap_n + 1;
      end
      if (rx_err_o) err_n = err_n + 1;
    end
  end

  typedef struct packed {
    logic [7:0] code;
    logic [1:0] spd;
    logic [3:0] nbytes;
    logic [7:0] seed;
    logic [1:0] npre;
    logic [1:0] part;
    logic       bad;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 2'b00, 4'd3, 8'h3C, 2'd0, 2'd0, 1'b0},
    '{8'h3F, 2'b00, 4'd1, 8'hC5, 2'd1, 2'd0, 1'b0},
    '{8'h40, 2'b01, 4'd4, 8'h12, 2'd2, 2'd0, 1'b0},
    '{8'h4F, 2'b01, 4'd2, 8'h81, 2'd0, 2'd1, 1'b0},
    '{8'h50, 2'b10, 4'd5, 8'hE7, 2'd0, 2'd0, 1'b0},
    '{8'h50, 2'b10, 4'd1, 8'h00, 2'd3, 2'd0, 1'b0},
    '{8'h00, 2'b00, 4'd2, 8'h6B, 2'd0, 2'd3, 1'b0},
    '{8'h00, 2'b00, 4'd0, 8'h00, 2'd0, 2'd0, 1'b0},
    '{8'h51, 2'b10, 4'd2, 8'h44, 2'd0, 2'd0, 1'b1},
    '{8'h80, 2'b00, 4'd2, 8'h55, 2'd0, 2'd0, 1'b1},
    '{8'h60, 2'b01, 4'd1, 8'h66, 2'd1, 2'd0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic send(input logic [1:0] c, input logic [7:0] d);
    @(posedge clk);
    #1;
    ctl_i = c;
    dat_i = d;
  endtask

  task automatic clear_cap();
    @(posedge clk);
    #1;
    cap_n = 0;
    err_n = 0;
  endtask

  task automatic flush();
    send(2'b00, 8'h00);
    send(2'b00, 8'hA5);
    send(2'b00, 8'hFF);
    send(2'b00, 8'h3C);
  endtask

  function automatic logic [7:0] pbyte(input logic [7:0] seed, input int i);
    return seed + 8'(i * 29);
  endfunction

  task automatic send_byte(input logic [7:0] b, input int k);
    logic [7:0] hm;
    hm = 8'hFF << (8 - k);
    for (int c = 0; c < 8 / k; c++)
      send(2'b10, (8'(b << (c * k)) & hm) | (8'h5A & ~hm));
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int k, exp_n, exp_e;
    k = v.bad ? 8 : (v.spd == 2'b00 ? 2 : (v.spd == 2'b01 ? 4 : 8));
    exp_n = v.bad ? 0 : int'(v.nbytes);
    exp_e = (v.bad || v.part != 0) ? 1 : 0;
    clear_cap();
    send(2'b10, 8'hFF);
    for (int p = 0; p < int'(v.npre); p++) send(2'b10, 8'hC3);
    send(2'b10, v.code);
    for (int i = 0; i < int'(v.nbytes); i++) send_byte(pbyte(v.seed, i), k);
    for (int p = 0; p < int'(v.part); p++) send(2'b10, 8'hC0 ^ 8'(p));
    flush();
    // R4 R8 R10: byte count with speed and prefix bytes excluded
    chk(cap_n == exp_n, $sformatf("R4 vec%0d byte count", idx), cap_n, exp_n);
    // R9 R10: error pulse count
    chk(err_n == exp_e, $sformatf("R9/R10 vec%0d error pulses", idx), err_n, exp_e);
    if (cap_n == exp_n) begin
      for (int i = 0; i < exp_n; i++) begin
        chk(cap_data[i] == pbyte(v.seed, i), $sformatf("R5 vec%0d byte%0d", idx, i),
            cap_data[i], pbyte(v.seed, i));
        chk(cap_spd[i] == v.spd, $sformatf("R3 vec%0d speed", idx), cap_spd[i], v.spd);
        chk(cap_sop[i] == (i == 0), $sformatf("R6 vec%0d sop byte%0d", idx, i),
            cap_sop[i], (i == 0));
        chk(cap_last[i] == (i == exp_n - 1), $sformatf("R7 vec%0d last byte%0d", idx, i),
            cap_last[i], (i == exp_n - 1));
      end
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk = n_chk + 1;
    n_bad = n_bad + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    n_chk = 0; n_bad = 0; cap_n = 0; err_n = 0; done = 1'b0;
    rst_n = 1'b0;
    ctl_i = 2'b10;
    dat_i = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(!rx_valid_o && !rx_sop_o && !rx_last_o && !rx_err_o, "R1 outputs in reset",
        {rx_valid_o, rx_sop_o, rx_last_o, rx_err_o}, 0);
    @(posedge clk);
    #1;
    ctl_i = 2'b00;
    dat_i = 8'h00;
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) run_vec(VECS[v], v);

    // R2: data ignored while idle, and odd control codes and non-prefix data while waiting
    clear_cap();
    for (int i = 0; i < 4; i++) send(2'b00, 8'hFF);
    send(2'b01, 8'hFF);
    send(2'b11, 8'hFF);
    send(2'b10, 8'h50);
    send(2'b10, 8'hA5);
    send(2'b10, 8'h3C);
    flush();
    chk(cap_n == 0, "R2 no bytes without prefix", cap_n, 0);
    chk(err_n == 0, "R2 no error without prefix", err_n, 0);

    // R8: prefix straight to idle
    clear_cap();
    send(2'b10, 8'hFF);
    send(2'b10, 8'hFF);
    flush();
    chk(cap_n == 0, "R8 probe gives no bytes", cap_n, 0);
    chk(err_n == 0, "R8 probe gives no error", err_n, 0);

    // R11: abort, then ignore until idle, then recover
    clear_cap();
    send(2'b10, 8'hFF);
    send(2'b10, 8'h50);
    send(2'b10, 8'h11);
    send(2'b10, 8'h22);
    send(2'b11, 8'h00);
    send(2'b10, 8'hFF);
    send(2'b10, 8'h50);
    send(2'b10, 8'h33);
    send(2'b10, 8'h44);
    flush();
    chk(cap_n == 1, "R11 bytes before abort", cap_n, 1);
    chk(err_n == 1, "R11 abort error pulse", err_n, 1);
    if (cap_n >= 1) begin
      chk(cap_data[0] == 8'h11, "R11 kept byte", cap_data[0], 8'h11);
      chk(cap_last[0] == 1'b0, "R11 no last after abort", cap_last[0], 0);
      chk(cap_sop[0] == 1'b1, "R6 sop on first byte", cap_sop[0], 1);
    end
    clear_cap();
    send(2'b10, 8'hFF);
    send(2'b10, 8'h50);
    send(2'b10, 8'h99);
    flush();
    chk(cap_n == 1 && cap_data[0] == 8'h99 && cap_last[0] && cap_sop[0],
        "R11 recovery packet", cap_n, 1);

    // R1: reset in the middle of a reception
    clear_cap();
    send(2'b10, 8'hFF);
    send(2'b10, 8'h50);
    send(2'b10, 8'h71);
    send(2'b10, 8'h72);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    @(negedge clk);
    chk(!rx_valid_o && !rx_err_o && !rx_sop_o && !rx_last_o, "R1 mid-packet reset",
        {rx_valid_o, rx_sop_o, rx_last_o, rx_err_o}, 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    send(2'b10, 8'h73);
    send(2'b00, 8'h00);
    clear_cap();
    send(2'b10, 8'hFF);
    send(2'b10, 8'h40);
    send_byte(8'hB6, 4);
    flush();
    chk(cap_n == 1, "R1 clean start after reset", cap_n, 1);
    if (cap_n >= 1)
      chk(cap_data[0] == 8'hB6 && cap_spd[0] == 2'b01 && cap_last[0], "R1 byte after reset",
          cap_data[0], 8'hB6);
    chk(err_n == 0, "R1 no error after reset", err_n, 0);

    report();
  end

endmodule